// File: doc/BRIEF.md
# Memory Dependence Wakeup Unit

This block sits beside the issue queue of an out-of-order core and holds every in-flight load, store and ordering barrier until it may issue. An operation leaves toward the issue queue only when two separate conditions hold. The first is that its register operands are ready. The second is that its memory ordering dependence is resolved. The dependence is taken from an active barrier when one applies. Otherwise it comes from a producer sequence number that an external predictor attaches to the insert. When a producer completes, the block wakes every operation that waits on it in one cycle.

Operations live in a fixed table searched by sequence number and thread id. The block takes one event per cycle through a command port. The events are: insert an operation, insert a barrier, registers ready, complete, squash a thread beyond a sequence number, mark an issued operation for replay, and replay. Released operations leave through a small FIFO with a valid/ready handshake. When several entries become releasable in the same cycle, they go out lowest table slot first. A new operation always takes the lowest free slot.

Top module: `memdep_wakeup`

## Requirements
- R1: After reset the ready output is not valid and the full flag is low.
- R2: A memory operation with no producer, or whose producer sequence number (after barrier selection) is zero or not held by any live entry, is memory-ready at insert. If it is inserted with registers ready, it appears on the ready output.
- R3: An operation inserted without ready registers is held until a registers-ready event names its sequence number and thread. It is then released if it is memory-ready.
- R4: An operation whose producer is a live entry is held even if its registers are ready. It is released when that producer completes.
- R5: A dependent that lacks ready registers when its producer completes becomes memory-ready. It is released on its later registers-ready event.
- R6: While a full barrier is active, newly inserted loads and stores depend on it instead of on their predicted producer. While only a write barrier is active, stores depend on it and loads keep their predicted producer.
- R7: Completing a barrier clears a barrier register only if that register still holds the completing barrier's sequence number. A newer barrier recorded there stays in force.
- R8: A squash with sequence S and thread T removes every entry of thread T whose sequence number is greater than S. Removed entries are never released. Older entries and other threads are untouched.
- R9: A reschedule marks an already released, ready entry. A replay releases all marked entries together. Squashed entries lose their mark.
- R10: Entries that become releasable in the same cycle leave in ascending table slot order. A new entry takes the lowest free slot.
- R11: The full flag is high while every slot is occupied, and an insert is then ignored. A completed entry keeps its slot for one more cycle and is free after the next clock edge.
- R12: While the ready output is valid and not accepted, its sequence number and thread hold steady.
- R13: cmd_op selects the event: 1 insert load/store, 2 insert barrier, 3 registers ready, 4 complete, 5 squash, 6 reschedule, 7 replay. Code 0, or cmd_valid low, does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | An event is present this cycle |
| cmd_op | input | 3 | Event code (see R13) |
| cmd_seq | input | SEQ_W | Sequence number the event refers to |
| cmd_tid | input | TID_W | Thread id of the event |
| cmd_store | input | 1 | Insert: 1 store, 0 load |
| cmd_full_bar | input | 1 | Barrier insert: 1 full barrier, 0 write barrier |
| cmd_regs_rdy | input | 1 | Insert: register operands already ready |
| cmd_pred | input | SEQ_W | Insert: predicted producer sequence number, 0 for none |
| tbl_full | output | 1 | No free table slot |
| rdy_valid | output | 1 | A released operation is offered |
| rdy_ready | input | 1 | Issue queue accepts the offered operation |
| rdy_seq | output | SEQ_W | Sequence number of the offered operation |
| rdy_tid | output | TID_W | Thread id of the offered operation |

## Verification
The bench builds the block with four table slots, a two-deep release FIFO, 8-bit sequence numbers and two threads. Four slots let a few inserts reach the full condition, the refused insert and the delayed slot reuse after completion. Freeing chosen slots then places dependents out of insertion order, which exposes the slot-order release rule. The two-deep FIFO forces a three-way wakeup to wait on backpressure, so ordering and output stability are exercised under stall.

// File: rtl/mdw_pkg.sv
package mdw_pkg;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_INS_MEM = 3'd1,
    OP_INS_BAR = 3'd2,
    OP_REGS    = 3'd3,
    OP_DONE    = 3'd4,
    OP_SQUASH  = 3'd5,
    OP_RESCHED = 3'd6,
    OP_REPLAY  = 3'd7
  } mdw_op_e;

  typedef enum logic [1:0] {
    K_LOAD     = 2'd0,
    K_STORE    = 2'd1,
    K_BAR_FULL = 2'd2,
    K_BAR_WR   = 2'd3
  } mdw_kind_e;

endpackage

// File: rtl/mdw_lowest.sv
module mdw_lowest #(
  parameter int N = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end

endmodule

// File: rtl/mdw_fifo.sv
module mdw_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  // storage without reset so it maps onto distributed or block RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R12: the producer side never pushes into a full FIFO
  p_fifo_no_overflow_r12: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);

  // R12: an offered word is held until it is taken
  p_fifo_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!empty && !pop) |=> (!empty && $stable(dout)));

endmodule

// File: rtl/memdep_wakeup.sv
module memdep_wakeup
  import mdw_pkg::*;
#(
  parameter int ENTRIES    = 16,
  parameter int SEQ_W      = 16,
  parameter int TID_W      = 2,
  parameter int FIFO_DEPTH = 4,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int OUT_W = SEQ_W + TID_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [SEQ_W-1:0] cmd_seq,
  input  logic [TID_W-1:0] cmd_tid,
  input  logic             cmd_store,
  input  logic             cmd_full_bar,
  input  logic             cmd_regs_rdy,
  input  logic [SEQ_W-1:0] cmd_pred,
  output logic             tbl_full,
  output logic             rdy_valid,
  input  logic             rdy_ready,
  output logic [SEQ_W-1:0] rdy_seq,
  output logic [TID_W-1:0] rdy_tid
);

  // ---------------- entry table ----------------
  logic [ENTRIES-1:0] e_val, e_dying, e_regs, e_mem, e_hasp, e_pend, e_rply;
  logic [SEQ_W-1:0]   e_seq  [ENTRIES];
  logic [TID_W-1:0]   e_tid  [ENTRIES];
  mdw_kind_e          e_kind [ENTRIES];
  logic [IDX_W-1:0]   e_prod [ENTRIES];

  // barrier registers
  logic             lb_v, sb_v;
  logic [SEQ_W-1:0] lb_seq, sb_seq;

  // ---------------- command decode ----------------
  mdw_op_e op;
  logic is_ins_mem, is_ins_bar, is_regs, is_done, is_sq, is_rs, is_rp;

  assign op         = cmd_valid ? mdw_op_e'(cmd_op) : OP_NONE;
  assign is_ins_mem = (op == OP_INS_MEM);
  assign is_ins_bar = (op == OP_INS_BAR);
  assign is_regs    = (op == OP_REGS);
  assign is_done    = (op == OP_DONE);
  assign is_sq      = (op == OP_SQUASH);
  assign is_rs      = (op == OP_RESCHED);
  assign is_rp      = (op == OP_REPLAY);

  // ---------------- lookups ----------------
  logic [ENTRIES-1:0] live, key_hit, prod_hit, kill, wake, pend_vis;
  logic [SEQ_W-1:0]   psel;
  logic [IDX_W-1:0]   key_idx, prod_idx, alloc_idx, push_idx;
  logic               key_found, prod_found, any_free, push_any, push;
  logic               fifo_full, fifo_empty;
  logic [OUT_W-1:0]   fifo_dout;

  assign live = e_val & ~e_dying;

  // producer choice: active barrier first, then the predicted producer
  always_comb begin
    if (!cmd_store && lb_v)      psel = lb_seq;
    else if (cmd_store && sb_v)  psel = sb_seq;
    else                         psel = cmd_pred;
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      key_hit[i]  = live[i] && (e_seq[i] == cmd_seq) && (e_tid[i] == cmd_tid);
      prod_hit[i] = live[i] && (psel != '0) && (e_seq[i] == psel);
      kill[i]     = is_sq && e_val[i] && (e_tid[i] == cmd_tid) && (e_seq[i] > cmd_seq);
    end
  end

  mdw_lowest #(.N(ENTRIES)) u_key (.req(key_hit),  .found(key_found),  .idx(key_idx));
  mdw_lowest #(.N(ENTRIES)) u_prd (.req(prod_hit), .found(prod_found), .idx(prod_idx));
  mdw_lowest #(.N(ENTRIES)) u_free(.req(~e_val),   .found(any_free),   .idx(alloc_idx));

  // dependents released by a completing producer or orphaned by a squash
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      wake[i] = live[i] && !kill[i] && e_hasp[i] &&
                ((is_done && key_found && (e_prod[i] == key_idx)) || kill[e_prod[i]]);
    end
  end

  assign pend_vis = e_pend & ~kill;
  mdw_lowest #(.N(ENTRIES)) u_push(.req(pend_vis), .found(push_any), .idx(push_idx));
  assign push = push_any && !fifo_full;

  assign tbl_full = !any_free;

  // ---------------- table update ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      e_val   <= '0;
      e_dying <= '0;
      e_regs  <= '0;
      e_mem   <= '0;
      e_hasp  <= '0;
      e_pend  <= '0;
      e_rply  <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        e_seq[i]  <= '0;
        e_tid[i]  <= '0;
        e_kind[i] <= K_LOAD;
        e_prod[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        // slot freed one cycle after completion
        if (e_dying[i]) begin
          e_val[i]   <= 1'b0;
          e_dying[i] <= 1'b0;
          e_pend[i]  <= 1'b0;
          e_rply[i]  <= 1'b0;
          e_hasp[i]  <= 1'b0;
        end
        if (push && (push_idx == IDX_W'(i))) e_pend[i] <= 1'b0;
        if (kill[i]) begin
          e_val[i]   <= 1'b0;
          e_dying[i] <= 1'b0;
          e_pend[i]  <= 1'b0;
          e_rply[i]  <= 1'b0;
          e_hasp[i]  <= 1'b0;
        end
        if (wake[i]) begin
          e_hasp[i] <= 1'b0;
          e_mem[i]  <= 1'b1;
          if (e_regs[i]) e_pend[i] <= 1'b1;
        end
        if (key_found && (key_idx == IDX_W'(i))) begin
          if (is_regs && (e_kind[i] == K_LOAD || e_kind[i] == K_STORE)) begin
            e_regs[i] <= 1'b1;
            if (e_mem[i]) e_pend[i] <= 1'b1;
          end
          if (is_done) begin
            e_dying[i] <= 1'b1;
            e_pend[i]  <= 1'b0;
            e_rply[i]  <= 1'b0;
          end
          if (is_rs && e_mem[i] && e_regs[i]) e_rply[i] <= 1'b1;
        end
        if (is_rp && e_rply[i]) begin
          e_rply[i] <= 1'b0;
          e_pend[i] <= 1'b1;
        end
        if (any_free && (alloc_idx == IDX_W'(i)) && (is_ins_mem || is_ins_bar)) begin
          e_val[i]   <= 1'b1;
          e_dying[i] <= 1'b0;
          e_seq[i]   <= cmd_seq;
          e_tid[i]   <= cmd_tid;
          e_rply[i]  <= 1'b0;
          e_prod[i]  <= prod_idx;
          if (is_ins_mem) begin
            e_kind[i] <= cmd_store ? K_STORE : K_LOAD;
            e_regs[i] <= cmd_regs_rdy;
            e_mem[i]  <= !prod_found;
            e_hasp[i] <= prod_found;
            e_pend[i] <= cmd_regs_rdy && !prod_found;
          end else begin
            e_kind[i] <= cmd_full_bar ? K_BAR_FULL : K_BAR_WR;
            e_regs[i] <= 1'b0;
            e_mem[i]  <= 1'b0;
            e_hasp[i] <= 1'b0;
            e_pend[i] <= 1'b0;
          end
        end
      end
    end
  end

  // ---------------- barrier registers ----------------
  mdw_kind_e done_kind;
  assign done_kind = e_kind[key_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      lb_v   <= 1'b0;
      sb_v   <= 1'b0;
      lb_seq <= '0;
      sb_seq <= '0;
    end else if (is_ins_bar && any_free) begin
      sb_v   <= 1'b1;
      sb_seq <= cmd_seq;
      if (cmd_full_bar) begin
        lb_v   <= 1'b1;
        lb_seq <= cmd_seq;
      end
    end else if (is_done && key_found) begin
      if (done_kind == K_BAR_FULL && lb_seq == cmd_seq) lb_v <= 1'b0;
      if ((done_kind == K_BAR_FULL || done_kind == K_BAR_WR) && sb_seq == cmd_seq)
        sb_v <= 1'b0;
    end
  end

  // ---------------- release FIFO ----------------
  mdw_fifo #(.W(OUT_W), .DEPTH(FIFO_DEPTH)) u_out (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .din   ({e_tid[push_idx], e_seq[push_idx]}),
    .full  (fifo_full),
    .pop   (rdy_ready),
    .dout  (fifo_dout),
    .empty (fifo_empty)
  );

  assign rdy_valid = !fifo_empty;
  assign rdy_seq   = fifo_dout[SEQ_W-1:0];
  assign rdy_tid   = fifo_dout[OUT_W-1:SEQ_W];

  // ---------------- assertions ----------------
  // R11: an insert into a full table changes no occupancy
  p_full_refuse_r11: assert property (@(posedge clk) disable iff (rst)
    ((is_ins_mem || is_ins_bar) && tbl_full) |=> ($countones(e_val) <= $past($countones(e_val))));

  // R8: nothing younger of the squashed thread survives the squash
  p_squash_clears_r8: assert property (@(posedge clk) disable iff (rst)
    is_sq |=> ((e_val & $past(kill)) == '0));

  // R12: the offered operation is stable while stalled
  p_out_stable_r12: assert property (@(posedge clk) disable iff (rst)
    (rdy_valid && !rdy_ready) |=> (rdy_valid && $stable(rdy_seq) && $stable(rdy_tid)));

  // R4: a release is only ever queued for a memory-ready live entry
  for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
    p_pend_memready_r4: assert property (@(posedge clk) disable iff (rst)
      e_pend[g] |-> (e_mem[g] && e_val[g]));
  end

endmodule

// File: tb/memdep_wakeup_tb_top.sv
module memdep_wakeup_tb_top;

  localparam int SW = 8;
  localparam int TW = 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [SW-1:0] cmd_seq = '0;
  logic [TW-1:0] cmd_tid = '0;
  logic          cmd_store = 1'b0;
  logic          cmd_full_bar = 1'b0;
  logic          cmd_regs_rdy = 1'b0;
  logic [SW-1:0] cmd_pred = '0;
  logic          tbl_full;
  logic          rdy_valid;
  logic          rdy_ready = 1'b0;
  logic [SW-1:0] rdy_seq;
  logic [TW-1:0] rdy_tid;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  memdep_wakeup #(.ENTRIES(4), .SEQ_W(SW), .TID_W(TW), .FIFO_DEPTH(2)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_seq(cmd_seq),
    .cmd_tid(cmd_tid), .cmd_store(cmd_store), .cmd_full_bar(cmd_full_bar),
    .cmd_regs_rdy(cmd_regs_rdy), .cmd_pred(cmd_pred), .tbl_full(tbl_full),
    .rdy_valid(rdy_valid), .rdy_ready(rdy_ready), .rdy_seq(rdy_seq), .rdy_tid(rdy_tid));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    rdy_ready = 1'b0;
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send(input int op, input int seq, input int tid, input bit st,
                      input bit fb, input bit rr, input int pred);
    cmd_valid    = 1'b1;
    cmd_op       = 3'(op);
    cmd_seq      = SW'(seq);
    cmd_tid      = TW'(tid);
    cmd_store    = st;
    cmd_full_bar = fb;
    cmd_regs_rdy = rr;
    cmd_pred     = SW'(pred);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic ins(input int seq, input bit st, input bit rr, input int pred, input int tid = 0);
    send(1, seq, tid, st, 1'b0, rr, pred);
  endtask
  task automatic bar(input int seq, input bit full); send(2, seq, 0, 1'b0, full, 1'b0, 0); endtask
  task automatic regs(input int seq, input int tid = 0); send(3, seq, tid, 1'b0, 1'b0, 1'b0, 0); endtask
  task automatic done(input int seq, input int tid = 0); send(4, seq, tid, 1'b0, 1'b0, 1'b0, 0); endtask
  task automatic squash(input int seq, input int tid); send(5, seq, tid, 1'b0, 1'b0, 1'b0, 0); endtask
  task automatic idle(input int n); repeat (n) @(negedge clk); endtask

  task automatic expect_pop(input int exp, input string tag);
    int waited = 0;
    while (!rdy_valid && waited < 10) begin
      @(negedge clk);
      waited++;
    end
    check(rdy_valid && (rdy_seq == SW'(exp)), tag, rdy_valid ? int'(rdy_seq) : -1, exp);
    if (rdy_valid) begin
      rdy_ready = 1'b1;
      @(negedge clk);
      rdy_ready = 1'b0;
    end
  endtask

  task automatic expect_none(input string tag);
    idle(4);
    check(!rdy_valid, tag, rdy_valid ? int'(rdy_seq) : -1, -1);
  endtask

  // R1, R13
  task automatic t_reset();
    do_reset();
    check(!rdy_valid, "R1 ready after reset", int'(rdy_valid), 0);
    check(!tbl_full, "R1 full after reset", int'(tbl_full), 0);
    send(0, 3, 0, 1'b0, 1'b0, 1'b1, 0);
    expect_none("R13 code 0 does nothing");
    check(!tbl_full, "R13 no slot taken", int'(tbl_full), 0);
  endtask

  // R2
  task automatic t_nodep();
    do_reset();
    ins(5, 1'b0, 1'b1, 0);
    expect_pop(5, "R2 load without producer");
    ins(6, 1'b1, 1'b1, 77);
    expect_pop(6, "R2 store with unmatched producer");
  endtask

  // R3
  task automatic t_regs();
    do_reset();
    ins(8, 1'b0, 1'b0, 0);
    expect_none("R3 held without registers");
    regs(8);
    expect_pop(8, "R3 released on registers ready");
  endtask

  // R4, R5
  task automatic t_dep();
    do_reset();
    ins(10, 1'b1, 1'b1, 0);
    expect_pop(10, "R2 producer store");
    ins(11, 1'b0, 1'b1, 10);
    ins(12, 1'b0, 1'b0, 10);
    expect_none("R4 dependent held");
    done(10);
    expect_pop(11, "R4 woken by producer completion");
    expect_none("R5 dependent waits on registers");
    regs(12);
    expect_pop(12, "R5 released after registers");
  endtask

  // R6, R7
  task automatic t_barrier();
    do_reset();
    bar(20, 1'b1);
    ins(21, 1'b0, 1'b1, 0);
    expect_none("R6 full barrier holds load");
    done(20);
    expect_pop(21, "R6 load released by barrier completion");
    idle(1);
    ins(22, 1'b0, 1'b1, 0);
    expect_pop(22, "R7 load barrier cleared");
    done(21); done(22); idle(1);
    bar(30, 1'b0);
    ins(31, 1'b0, 1'b1, 0);
    expect_pop(31, "R6 write barrier leaves loads");
    ins(32, 1'b1, 1'b1, 0);
    expect_none("R6 write barrier holds store");
    done(30);
    expect_pop(32, "R6 store released");
    // newer barrier survives an older completion
    do_reset();
    bar(40, 1'b1);
    bar(41, 1'b0);
    done(40);
    idle(1);
    ins(42, 1'b1, 1'b1, 0);
    expect_none("R7 newer write barrier survives");
    ins(43, 1'b0, 1'b1, 0);
    expect_pop(43, "R7 load barrier cleared by match");
    done(41);
    expect_pop(42, "R7 store released by newer barrier");
  endtask

  // R8
  task automatic t_squash();
    do_reset();
    ins(50, 1'b1, 1'b0, 0, 0);
    ins(51, 1'b0, 1'b1, 50, 0);
    ins(52, 1'b0, 1'b0, 0, 1);
    ins(53, 1'b1, 1'b0, 0, 0);
    squash(50, 0);
    regs(53, 0);
    expect_none("R8 squashed entry ignores registers ready");
    done(50, 0);
    expect_none("R8 squashed dependent never released");
    regs(52, 1);
    expect_pop(52, "R8 other thread untouched");
  endtask

  // R9
  task automatic t_replay();
    do_reset();
    ins(60, 1'b0, 1'b1, 0);
    expect_pop(60, "R9 first issue 60");
    ins(61, 1'b0, 1'b1, 0);
    expect_pop(61, "R9 first issue 61");
    ins(62, 1'b0, 1'b1, 0);
    expect_pop(62, "R9 first issue 62");
    send(6, 60, 0, 1'b0, 1'b0, 1'b0, 0);
    send(6, 62, 0, 1'b0, 1'b0, 1'b0, 0);
    send(6, 61, 0, 1'b0, 1'b0, 1'b0, 0);
    expect_none("R9 marked entries wait for replay");
    squash(61, 0);
    send(7, 0, 0, 1'b0, 1'b0, 1'b0, 0);
    expect_pop(60, "R9 replay 60");
    expect_pop(61, "R9 replay 61");
    expect_none("R9 squashed mark dropped");
  endtask

  // R10, R11
  task automatic t_order();
    do_reset();
    ins(10, 1'b0, 1'b0, 0);
    ins(11, 1'b0, 1'b0, 0);
    ins(12, 1'b1, 1'b0, 0);
    ins(13, 1'b0, 1'b0, 0);
    check(tbl_full, "R11 full with all slots used", int'(tbl_full), 1);
    ins(99, 1'b0, 1'b1, 0);
    expect_none("R11 insert refused when full");
    done(11);
    check(tbl_full, "R11 slot held one cycle", int'(tbl_full), 1);
    idle(1);
    check(!tbl_full, "R11 slot freed", int'(tbl_full), 0);
    ins(20, 1'b0, 1'b1, 12);
    done(10); idle(1);
    ins(21, 1'b0, 1'b1, 12);
    done(13); idle(1);
    ins(22, 1'b0, 1'b1, 12);
    expect_none("R10 dependents held");
    done(12);
    expect_pop(21, "R10 lowest slot first");
    expect_pop(20, "R10 second slot");
    expect_pop(22, "R10 last slot");
  endtask

  // R12
  task automatic t_hold();
    do_reset();
    ins(70, 1'b0, 1'b1, 0);
    ins(71, 1'b0, 1'b1, 0);
    idle(3);
    check(rdy_valid && rdy_seq == 8'd70, "R12 offered first", int'(rdy_seq), 70);
    idle(3);
    check(rdy_valid && rdy_seq == 8'd70, "R12 held while stalled", int'(rdy_seq), 70);
    expect_pop(70, "R12 pop 70");
    expect_pop(71, "R12 pop 71");
  endtask

  initial begin
    t_reset();
    t_nodep();
    t_regs();
    t_dep();
    t_barrier();
    t_squash();
    t_replay();
    t_order();
    t_hold();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule